// File: doc/BRIEF.md
# BCD Time-of-Day Alarm Comparator

This block watches a running calendar clock, given as BCD seconds, minutes, hours and day-of-month, and raises an alarm when the clock reaches a programmed point. Four alarm bytes hold the target second, minute, hour and date. The top bit of each alarm byte is a repeat bit. Together the four repeat bits choose how many of the time fields must match: none (every second), seconds only (once a minute), seconds and minutes (hourly), seconds through hours (daily), or all four fields (monthly). The comparison runs only on a once-per-second update strobe, so each second can set the flag at most once.

A match sets a sticky alarm flag. The flag drives the interrupt output only when the interrupt enable is set. While the system runs on backup power, a second enable must also be set before the interrupt can fire. Software reads the flag through a small register port, and that read clears both the flag and the interrupt. The calendar counting itself is done elsewhere. This block only compares values and keeps the alarm state.

Top module: `alarm_matcher`

## Requirements
- R1: After a synchronous reset, every register reads 0x00, the alarm flag is clear and `irq` is low.
- R2: Register selects are 0 = alarm seconds, 1 = alarm minutes, 2 = alarm hours, 3 = alarm date (all eight bits stored and read back), 4 = control, 5 = flags (read-only). The control byte keeps only bit 7 (interrupt enable) and bit 5 (backup enable), and its other bits read 0. Selects 6 and 7 ignore writes and read 0x00. `rd_data` is registered: it shows the selected byte in the cycle after `rd_en` and holds that value otherwise.
- R3: With repeat code 1111 (bit order date.7, hours.7, minutes.7, seconds.7), every update strobe is a match.
- R4: Code 1110 matches on seconds alone. Code 1100 matches on seconds and minutes. Code 1000 matches on seconds, minutes and hours.
- R5: Code 0000 matches only when seconds, minutes, hours and date are all equal.
- R6: Any other repeat code behaves as 1111 and matches on every strobe.
- R7: Comparison uses bits 6:0 of each field only. Bit 7 of the incoming time has no effect.
- R8: Without an update strobe, a matching time never sets the flag.
- R9: A match sets the flag (flags byte bit 6). `irq` rises in the cycle after the strobe only if control bit 7 is set. Otherwise only the flag is set.
- R10: While `backup` is high, a match raises `irq` only if control bits 7 and 5 are both set.
- R11: A read of the flags register returns the flag as it stood before the read, then clears the flag and `irq`. If a match strobe falls in the same cycle as that read, the match wins and the flag (and `irq` if enabled) stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Once-per-second update strobe |
| now_sec | input | 8 | Current seconds, BCD |
| now_min | input | 8 | Current minutes, BCD |
| now_hour | input | 8 | Current hours, BCD |
| now_date | input | 8 | Current day of month, BCD |
| backup | input | 1 | High while on backup power |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Write register select |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 3 | Read register select |
| rd_data | output | 8 | Registered read data |
| irq | output | 1 | Alarm interrupt, active high |

## Verification
The clear caused by a flags read and the set caused by a match strobe can land on the same clock edge. The bench provokes this by driving `tick` with a matching time and `rd_en` on the flags select in the same cycle. It does this once with the flag clear beforehand and once with it already set. In both cases it judges that the returned byte shows the earlier flag, that `irq` ends high, and that a following read still reports the flag.

// File: rtl/alarm_matcher_pkg.sv
package alarm_matcher_pkg;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned SEL_W  = 3;
    localparam int unsigned FIELDS = 4;

    // bit positions inside control and flags bytes
    localparam int unsigned CTRL_IE_BIT = 7;
    localparam int unsigned CTRL_BK_BIT = 5;
    localparam int unsigned FLAG_AF_BIT = 6;

    typedef enum logic [SEL_W-1:0] {
        SEL_SEC  = 3'd0,
        SEL_MIN  = 3'd1,
        SEL_HOUR = 3'd2,
        SEL_DATE = 3'd3,
        SEL_CTRL = 3'd4,
        SEL_FLAG = 3'd5
    } reg_sel_e;

    typedef enum logic [2:0] {
        RM_SECOND,
        RM_MINUTE,
        RM_HOUR,
        RM_DAY,
        RM_MONTH
    } rep_mode_e;

    // field 0 = seconds ... field 3 = date
    typedef struct packed {
        logic [BYTE_W-1:0] date;
        logic [BYTE_W-1:0] hour;
        logic [BYTE_W-1:0] min;
        logic [BYTE_W-1:0] sec;
    } tstamp_t;

    // code bit 3 comes from date, bit 0 from seconds
    function automatic rep_mode_e decode_rpt(input logic [FIELDS-1:0] code);
        case (code)
            4'b1110: return RM_MINUTE;
            4'b1100: return RM_HOUR;
            4'b1000: return RM_DAY;
            4'b0000: return RM_MONTH;
            default: return RM_SECOND;
        endcase
    endfunction

    // which fields must be equal for a hit
    function automatic logic [FIELDS-1:0] need_mask(input rep_mode_e m);
        case (m)
            RM_MINUTE: return 4'b0001;
            RM_HOUR:   return 4'b0011;
            RM_DAY:    return 4'b0111;
            RM_MONTH:  return 4'b1111;
            default:   return 4'b0000;
        endcase
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_matcher_pkg::*;
#(
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned SW = SEL_W,
    parameter int unsigned NF = FIELDS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [SW-1:0]    wr_sel,
    input  logic [DW-1:0]    wr_data,
    input  logic             rd_en,
    input  logic [SW-1:0]    rd_sel,
    input  logic             af,
    output logic [NF*DW-1:0] alarm_bus,
    output logic             ie,
    output logic             bk,
    output logic             flag_rd,
    output logic [DW-1:0]    rd_data
);

    logic [NF-1:0][DW-1:0] alm;
    logic [DW-1:0]         rd_mux;
    logic [DW-1:0]         rd_q;
    logic                  ie_q;
    logic                  bk_q;

    for (genvar i = 0; i < NF; i++) begin : g_fld
        logic [DW-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (wr_en && wr_sel == SW'(i)) begin
                q <= wr_data;
            end
        end
        assign alm[i] = q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ie_q <= 1'b0;
            bk_q <= 1'b0;
        end else if (wr_en && wr_sel == SEL_CTRL) begin
            ie_q <= wr_data[CTRL_IE_BIT];
            bk_q <= wr_data[CTRL_BK_BIT];
        end
    end

    always_comb begin
        rd_mux = '0;
        for (int i = 0; i < NF; i++) begin
            if (rd_sel == SW'(i)) begin
                rd_mux = alm[i];
            end
        end
        if (rd_sel == SEL_CTRL) begin
            rd_mux[CTRL_IE_BIT] = ie_q;
            rd_mux[CTRL_BK_BIT] = bk_q;
        end
        if (rd_sel == SEL_FLAG) begin
            rd_mux[FLAG_AF_BIT] = af;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_mux;
        end
    end

    assign alarm_bus = alm;
    assign ie        = ie_q;
    assign bk        = bk_q;
    assign flag_rd   = rd_en && (rd_sel == SEL_FLAG);
    assign rd_data   = rd_q;

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_matcher_pkg::*;
#(
    parameter int unsigned DW = BYTE_W,
    parameter int unsigned NF = FIELDS
) (
    input  logic [NF*DW-1:0] now_bus,
    input  logic [NF*DW-1:0] alarm_bus,
    output logic             hit
);

    localparam int unsigned CW = DW - 1;

    logic [NF-1:0] eq;
    logic [NF-1:0] rpt;
    logic [NF-1:0] need;
    logic [NF-1:0] unused_now_msb;
    rep_mode_e     mode;

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        logic [DW-1:0] n_b;
        logic [DW-1:0] a_b;
        assign n_b               = now_bus[i*DW +: DW];
        assign a_b               = alarm_bus[i*DW +: DW];
        assign eq[i]             = (n_b[CW-1:0] == a_b[CW-1:0]);
        assign rpt[i]            = a_b[CW];
        assign unused_now_msb[i] = n_b[CW];
    end

    assign mode = decode_rpt(rpt);
    assign need = need_mask(mode);
    assign hit  = &(eq | ~need);

endmodule

// File: rtl/alarm_flag.sv
module alarm_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    input  logic flag_rd,
    input  logic ie,
    input  logic bk,
    input  logic backup,
    output logic af,
    output logic irq
);

    logic set_ev;
    logic irq_ok;
    logic af_q;
    logic irq_q;

    assign set_ev = tick && hit;
    assign irq_ok = ie && (!backup || bk);

    always_ff @(posedge clk) begin
        if (rst) begin
            af_q <= 1'b0;
        end else if (set_ev) begin
            af_q <= 1'b1;
        end else if (flag_rd) begin
            af_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else if (set_ev && irq_ok) begin
            irq_q <= 1'b1;
        end else if (flag_rd) begin
            irq_q <= 1'b0;
        end
    end

    assign af  = af_q;
    assign irq = irq_q;

endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
    import alarm_matcher_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic [BYTE_W-1:0] now_sec,
    input  logic [BYTE_W-1:0] now_min,
    input  logic [BYTE_W-1:0] now_hour,
    input  logic [BYTE_W-1:0] now_date,
    input  logic              backup,
    input  logic              wr_en,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [SEL_W-1:0]  rd_sel,
    output logic [BYTE_W-1:0] rd_data,
    output logic              irq
);

    tstamp_t                   now_ts;
    logic [FIELDS*BYTE_W-1:0]  alarm_bus;
    logic                      ie;
    logic                      bk;
    logic                      flag_rd;
    logic                      hit;
    logic                      af;

    assign now_ts = '{date: now_date, hour: now_hour, min: now_min, sec: now_sec};

    alarm_regs #(.DW(BYTE_W), .SW(SEL_W), .NF(FIELDS)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_sel    (rd_sel),
        .af        (af),
        .alarm_bus (alarm_bus),
        .ie        (ie),
        .bk        (bk),
        .flag_rd   (flag_rd),
        .rd_data   (rd_data)
    );

    alarm_cmp #(.DW(BYTE_W), .NF(FIELDS)) u_cmp (
        .now_bus   (now_ts),
        .alarm_bus (alarm_bus),
        .hit       (hit)
    );

    alarm_flag u_flag (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .hit     (hit),
        .flag_rd (flag_rd),
        .ie      (ie),
        .bk      (bk),
        .backup  (backup),
        .af      (af),
        .irq     (irq)
    );

endmodule

// File: rtl/alarm_matcher_chk.sv
module alarm_matcher_chk
    import alarm_matcher_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic             hit,
    input logic             rd_en,
    input logic [SEL_W-1:0] rd_sel,
    input logic             af,
    input logic             irq,
    input logic             ie,
    input logic             bk,
    input logic             backup
);

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (!af && !irq));

    p_no_flag_without_tick_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(af) |-> $past(tick && hit));

    p_strobe_hit_sets_r9: assert property (@(posedge clk) disable iff (rst)
        (tick && hit) |=> af);

    p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (rst)
        irq |-> af);

    p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(ie));

    p_backup_gate_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(!backup) || $past(bk)));

    p_read_clears_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == SEL_FLAG && !(tick && hit)) |=> (!af && !irq));

endmodule

bind alarm_matcher alarm_matcher_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .hit    (hit),
    .rd_en  (rd_en),
    .rd_sel (rd_sel),
    .af     (af),
    .irq    (irq),
    .ie     (ie),
    .bk     (bk),
    .backup (backup)
);

// File: tb/alarm_matcher_tb.sv
`timescale 1ns/1ps
module alarm_matcher_tb;

    logic       clk = 1'b0;
    logic       rst, tick, backup, wr_en, rd_en;
    logic [7:0] now_sec, now_min, now_hour, now_date, wr_data;
    logic [2:0] wr_sel, rd_sel;
    wire  [7:0] rd_data;
    wire        irq;

    always #2.5 clk = ~clk;

    alarm_matcher u_dut (
        .clk(clk), .rst(rst), .tick(tick),
        .now_sec(now_sec), .now_min(now_min), .now_hour(now_hour), .now_date(now_date),
        .backup(backup), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .irq(irq)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } sb_item_t;
    sb_item_t sb_q[$];

    logic [7:0] sh_alm [4];
    logic [7:0] sh_ctrl;
    logic       rd_seen;

    // monitor: read data is valid at the negedge after the edge that saw rd_en
    always @(posedge clk) rd_seen <= rd_en;

    always @(negedge clk) begin
        sb_item_t it;
        if (rd_seen === 1'b1) begin
            n_cmp++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: unexpected read, actual %h expected none", rd_data);
            end else begin
                it = sb_q.pop_front();
                if (rd_data !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: rd_data actual %h expected %h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic chk_irq(input logic e, input string tag);
        n_cmp++;
        if (irq !== e) begin
            n_bad++;
            $display("FAIL %s: irq actual %b expected %b", tag, irq, e);
        end
    endtask

    task automatic write_reg(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        if (sel < 3'd4) sh_alm[sel[1:0]] = d;
        else if (sel == 3'd4) sh_ctrl = d & 8'hA0;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_expect(input logic [2:0] sel, input logic [7:0] e, input string tag);
        sb_item_t it;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        rd_en = 1'b1; rd_sel = sel;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_alarm(input logic [7:0] s, m, h, d);
        write_reg(3'd0, s); write_reg(3'd1, m); write_reg(3'd2, h); write_reg(3'd3, d);
    endtask

    function automatic logic ref_hit(input logic [7:0] s, m, h, d);
        logic [7:0] tv [4];
        logic [3:0] code;
        int         need;
        logic       r;
        tv[0] = s; tv[1] = m; tv[2] = h; tv[3] = d;
        code = {sh_alm[3][7], sh_alm[2][7], sh_alm[1][7], sh_alm[0][7]};
        case (code)
            4'b1110: need = 1;
            4'b1100: need = 2;
            4'b1000: need = 3;
            4'b0000: need = 4;
            default: need = 0;
        endcase
        r = 1'b1;
        for (int i = 0; i < need; i++)
            if (tv[i][6:0] != sh_alm[i][6:0]) r = 1'b0;
        return r;
    endfunction

    task automatic drive_time(input logic [7:0] s, m, h, d);
        now_sec = s; now_min = m; now_hour = h; now_date = d;
    endtask

    // one strobe, check irq, read flags (clears), check irq dropped
    task automatic tick_case(input logic [7:0] s, m, h, d, input string tag);
        logic eh, ei;
        eh = ref_hit(s, m, h, d);
        ei = eh && sh_ctrl[7] && (!backup || sh_ctrl[5]);
        drive_time(s, m, h, d);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        chk_irq(ei, tag);
        read_expect(3'd5, eh ? 8'h40 : 8'h00, tag);
        chk_irq(1'b0, {tag, " R11 clear"});
    endtask

    // strobe and flags read in the same cycle
    task automatic tick_with_read(input logic [7:0] s, m, h, d, input logic [7:0] e_rd);
        sb_item_t it;
        it.exp = e_rd; it.tag = "R11 same-cycle read";
        sb_q.push_back(it);
        drive_time(s, m, h, d);
        tick = 1'b1; rd_en = 1'b1; rd_sel = 3'd5;
        @(negedge clk);
        tick = 1'b0; rd_en = 1'b0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run hung, actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; backup = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_sel = '0; rd_sel = '0; wr_data = '0;
        drive_time(8'h00, 8'h00, 8'h00, 8'h00);
        for (int i = 0; i < 4; i++) sh_alm[i] = 8'h00;
        sh_ctrl = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk_irq(1'b0, "R1");
        for (int i = 0; i < 6; i++) read_expect(3'(i), 8'h00, "R1");

        // R2 register map
        set_alarm(8'h59, 8'hC3, 8'h23, 8'h31);
        write_reg(3'd4, 8'hFF);
        write_reg(3'd6, 8'h55);
        read_expect(3'd0, 8'h59, "R2 sec");
        read_expect(3'd1, 8'hC3, "R2 min");
        read_expect(3'd2, 8'h23, "R2 hour");
        read_expect(3'd3, 8'h31, "R2 date");
        read_expect(3'd4, 8'hA0, "R2 ctrl");
        read_expect(3'd6, 8'h00, "R2 unused sel");
        @(negedge clk);
        n_cmp++;
        if (rd_data !== 8'h00) begin
            n_bad++;
            $display("FAIL R2 hold: rd_data actual %h expected 00", rd_data);
        end

        // R3 every second
        write_reg(3'd4, 8'h80);
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        tick_case(8'h56, 8'h34, 8'h12, 8'h15, "R3 a");
        tick_case(8'h07, 8'h59, 8'h23, 8'h31, "R3 b");

        // R4 minute / hour / day
        set_alarm(8'h30, 8'hC5, 8'h90, 8'h85);
        tick_case(8'h30, 8'h11, 8'h02, 8'h09, "R4 1110 hit");
        tick_case(8'h31, 8'h45, 8'h10, 8'h05, "R4 1110 miss");
        write_reg(3'd1, 8'h45);
        tick_case(8'h30, 8'h45, 8'h22, 8'h09, "R4 1100 hit");
        tick_case(8'h30, 8'h44, 8'h10, 8'h05, "R4 1100 miss");
        write_reg(3'd2, 8'h10);
        tick_case(8'h30, 8'h45, 8'h10, 8'h27, "R4 1000 hit");
        tick_case(8'h30, 8'h45, 8'h11, 8'h05, "R4 1000 miss");

        // R5 month
        write_reg(3'd3, 8'h05);
        tick_case(8'h30, 8'h45, 8'h10, 8'h05, "R5 hit");
        tick_case(8'h30, 8'h45, 8'h10, 8'h06, "R5 date miss");
        tick_case(8'h30, 8'h45, 8'h09, 8'h05, "R5 hour miss");

        // R7 ignore bit 7 of current time
        tick_case(8'hB0, 8'hC5, 8'h90, 8'h85, "R7");

        // R8 no strobe, matching time
        drive_time(8'h30, 8'h45, 8'h10, 8'h05);
        repeat (3) @(negedge clk);
        chk_irq(1'b0, "R8");
        read_expect(3'd5, 8'h00, "R8");

        // R6 invalid codes
        set_alarm(8'h30, 8'hC5, 8'h10, 8'h85);
        tick_case(8'h00, 8'h01, 8'h02, 8'h03, "R6 1010");
        set_alarm(8'hB0, 8'h45, 8'h10, 8'h05);
        tick_case(8'h59, 8'h58, 8'h21, 8'h19, "R6 0001");

        // R9 flag without enable
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        write_reg(3'd4, 8'h00);
        tick_case(8'h12, 8'h12, 8'h12, 8'h12, "R9 disabled");
        write_reg(3'd4, 8'h80);
        tick_case(8'h13, 8'h12, 8'h12, 8'h12, "R9 enabled");

        // R10 backup mode
        backup = 1'b1;
        tick_case(8'h14, 8'h12, 8'h12, 8'h12, "R10 no bk");
        write_reg(3'd4, 8'h20);
        tick_case(8'h15, 8'h12, 8'h12, 8'h12, "R10 bk only");
        write_reg(3'd4, 8'hA0);
        tick_case(8'h16, 8'h12, 8'h12, 8'h12, "R10 both");
        backup = 1'b0;
        write_reg(3'd4, 8'h80);

        // R11 set and clear in the same cycle, flag clear before
        tick_with_read(8'h20, 8'h00, 8'h00, 8'h01, 8'h00);
        chk_irq(1'b1, "R11 same-cycle irq");
        read_expect(3'd5, 8'h40, "R11 after same-cycle");
        chk_irq(1'b0, "R11 cleared");

        // R11 with flag already set
        tick_case(8'h21, 8'h00, 8'h00, 8'h01, "R11 prep");
        drive_time(8'h22, 8'h00, 8'h00, 8'h01);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        tick_with_read(8'h23, 8'h00, 8'h00, 8'h01, 8'h40);
        chk_irq(1'b1, "R11 held irq");
        read_expect(3'd5, 8'h40, "R11 held flag");
        read_expect(3'd5, 8'h00, "R11 final clear");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
        end
        done = 1'b1;
        summary();
        $finish;
    end

endmodule